// File: doc/BRIEF.md
# Serial ADC Control and Power-Mode Logic

This block is the digital side of a serial analog-to-digital converter: it watches an active-low chip select, a serial clock and a data-in line, all sampled by the system clock, and answers on a data-out line. Each frame is sixteen serial clocks long. The head of the incoming word may rewrite a small control register that chooses the channel to tag and the power mode. The outgoing word carries a channel tag and a result taken from a stub sample input.

A power-mode state machine follows the mode bits and moves only on chip-select edges and on serial clocks while it waits for power-up. Normal operation, automatic sleep between frames, full shutdown and a timed power-up phase are modelled. The block flags every frame as valid or invalid: frames that start before the control register is set, while the part is shut down, or while the power-up timer runs return invalid data. Reset stands in for the supplies being applied.

Top module: `adc_power_ctrl`

## Requirements
- R1: While and after reset, `dout_oe` and `data_valid` are 0, `pwr_state` is 0 (on), and the control register is marked undefined.
- R2: `dout_oe` goes high one clock after `cs_n` falls and low one clock after `cs_n` rises.
- R3: Data-in is taken MSB first on serial-clock rising edges while `cs_n` is low. Of the first 12 bits, bit 11 is the write flag, bits 10:8 the channel and bits 7:6 the mode (11 or 00 on, 01 auto sleep, 10 full shutdown). Bits 5:0 are ignored. The register loads at the 12th rising edge when the write flag is 1. A frame that ends before its 12th edge loads nothing.
- R4: A frame whose write flag is 0 leaves channel and mode unchanged.
- R5: The first two frames after reset never load the control register. The third may load it. Every frame that starts while the register is undefined is invalid.
- R6: A valid frame shifts out {0, channel[2:0], sample[11:0]}, MSB first. The sample and the channel are taken at the `cs_n` falling edge. The first bit appears after that edge, and each serial-clock falling edge advances one bit. An invalid frame shifts out zeros.
- R7: In auto sleep mode, `pwr_state` becomes 1 on each `cs_n` rising edge. It returns to 0 on the next falling edge, and that frame is valid.
- R8: Mode 10 takes `pwr_state` to 2 at the `cs_n` rising edge. It stays 2 until a frame loads another mode, and frames that start in it are invalid.
- R9: A frame that loads mode on or auto sleep during full shutdown sets `pwr_state` to 3 at its `cs_n` rising edge. After PWRUP_SCLKS further serial-clock rising edges it returns to 0. Frames that start in state 3 are invalid, so the first frame after shutdown is always a dummy.
- R10: `data_valid` changes only at a `cs_n` falling edge and holds for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset (supply power-up) |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial control data, MSB first |
| sample_in | input | RES_W | Stub conversion result |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` (high impedance when 0) |
| data_valid | output | 1 | The current frame carries a real result |
| pwr_state | output | 2 | 0 on, 1 auto sleep, 2 full shutdown, 3 powering up |

## Verification
The bench builds the block with RES_W = 12 and PWRUP_SCLKS = 20. With these values the power-up window is longer than one frame and ends four edges into the next one. Both frames after a full-shutdown exit are therefore dummies, and the state returns to on in the middle of a frame. The bench also checks a frame that is cut short, the zero mode code, and the two blocked power-on frames.

// File: rtl/adc_pc_pkg.sv
package adc_pc_pkg;

    localparam int CTRL_W  = 12;
    localparam int CHAN_W  = 3;
    localparam int HEAD_W  = 1 + CHAN_W + 2;
    localparam int POR_FRAMES = 2;

    typedef enum logic [1:0] {
        PW_ON         = 2'd0,
        PW_AUTO_SLEEP = 2'd1,
        PW_FULL_OFF   = 2'd2,
        PW_WAKING     = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        MD_ALT_ON = 2'b00,
        MD_AUTO   = 2'b01,
        MD_FULL   = 2'b10,
        MD_ON     = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic              wr;
        logic [CHAN_W-1:0] chan;
        pwr_mode_e         mode;
    } ctrl_head_t;

    function automatic logic can_convert(pwr_state_e s);
        return (s == PW_ON) || (s == PW_AUTO_SLEEP);
    endfunction

    function automatic logic leaving_off(pwr_state_e s, pwr_mode_e m);
        return (s == PW_FULL_OFF) && (m != MD_FULL);
    endfunction

endpackage

// File: rtl/adc_pc_serial.sv
module adc_pc_serial
    import adc_pc_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               din,
    input  logic [FRAME_W-1:0] load_frame,
    output logic               cs_fall,
    output logic               cs_rise,
    output logic               sclk_rise,
    output logic               cap_evt,
    output ctrl_head_t         cap_word,
    output logic               dout,
    output logic               dout_oe
);

    localparam int CNT_W = $clog2(CTRL_W + 1);
    localparam logic [CNT_W-1:0] CAP_AT  = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CTRL_W);
    localparam logic [CNT_W-1:0] HEAD_N  = CNT_W'(HEAD_W);

    logic               cs_q;
    logic               sclk_q;
    logic               sclk_fall;
    logic [CNT_W-1:0]   bit_cnt;
    logic [HEAD_W-1:0]  head_sh;
    logic [FRAME_W-1:0] out_sh;
    logic               oe_q;

    assign cs_fall   = cs_q & ~cs_n;
    assign cs_rise   = ~cs_q & cs_n;
    assign sclk_rise = ~cs_n & ~sclk_q & sclk;
    assign sclk_fall = ~cs_n & sclk_q & ~sclk;
    assign cap_evt   = sclk_rise && (bit_cnt == CAP_AT);
    assign cap_word  = ctrl_head_t'(head_sh);
    assign dout      = out_sh[FRAME_W-1];
    assign dout_oe   = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            oe_q   <= ~cs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            head_sh <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            if (bit_cnt < HEAD_N)
                head_sh <= {head_sh[HEAD_W-2:0], din};
            if (bit_cnt < CNT_MAX)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_sh <= '0;
        else if (cs_fall)
            out_sh <= load_frame;
        else if (sclk_fall)
            out_sh <= {out_sh[FRAME_W-2:0], 1'b0};
    end

    assert_oe_on_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> dout_oe);
    assert_oe_off_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> !dout_oe);
    assert_dout_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !cs_fall && !sclk_fall) |=> $stable(dout));

endmodule

// File: rtl/adc_pc_ctrl_reg.sv
module adc_pc_ctrl_reg
    import adc_pc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_rise,
    input  logic       cap_evt,
    input  ctrl_head_t cap_word,
    output logic [CHAN_W-1:0] chan,
    output pwr_mode_e  mode,
    output logic       ctrl_def
);

    localparam int POR_W = $clog2(POR_FRAMES + 1);
    localparam logic [POR_W-1:0] POR_DONE = POR_W'(POR_FRAMES);

    logic [POR_W-1:0] por_cnt;
    logic             load_ok;

    assign load_ok = cap_evt && cap_word.wr && (por_cnt == POR_DONE);

    always_ff @(posedge clk) begin
        if (rst)
            por_cnt <= '0;
        else if (cs_rise && (por_cnt != POR_DONE))
            por_cnt <= por_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan     <= '0;
            mode     <= MD_ON;
            ctrl_def <= 1'b0;
        end else if (load_ok) begin
            chan     <= cap_word.chan;
            mode     <= cap_word.mode;
            ctrl_def <= 1'b1;
        end
    end

    assert_keep_on_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && !cap_word.wr) |=> ($stable(chan) && $stable(mode)));
    assert_por_block_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_def && (por_cnt != POR_DONE)) |=> !ctrl_def);

endmodule

// File: rtl/adc_pc_pwr_fsm.sv
module adc_pc_pwr_fsm
    import adc_pc_pkg::*;
#(
    parameter int PWRUP_SCLKS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic       sclk_rise,
    input  logic       ctrl_def,
    input  pwr_mode_e  mode,
    output pwr_state_e state
);

    localparam int PU_N = (PWRUP_SCLKS < 1) ? 1 : PWRUP_SCLKS;
    localparam int TW   = $clog2(PU_N + 1);
    localparam logic [TW-1:0] PU_LOAD = TW'(PU_N);
    localparam logic [TW-1:0] ONE     = TW'(1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PW_ON;
            tmr   <= '0;
        end else if (cs_rise && ctrl_def) begin
            if (mode == MD_FULL) begin
                state <= PW_FULL_OFF;
            end else if (leaving_off(state, mode)) begin
                state <= PW_WAKING;
                tmr   <= PU_LOAD;
            end else if (state != PW_WAKING) begin
                state <= (mode == MD_AUTO) ? PW_AUTO_SLEEP : PW_ON;
            end
        end else if (cs_fall && (state == PW_AUTO_SLEEP)) begin
            state <= PW_ON;
        end else if (sclk_rise && (state == PW_WAKING)) begin
            if (tmr == ONE) begin
                state <= PW_ON;
                tmr   <= '0;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    assert_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PW_FULL_OFF && !cs_rise) |=> (state == PW_FULL_OFF));
    assert_wake_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (state == PW_AUTO_SLEEP && cs_fall) |=> (state == PW_ON));
    assert_waking_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (state == PW_WAKING && !sclk_rise && !cs_rise) |=> (state == PW_WAKING));

endmodule

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl
    import adc_pc_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int PWRUP_SCLKS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] sample_in,
    output logic             dout,
    output logic             dout_oe,
    output logic             data_valid,
    output logic [1:0]       pwr_state
);

    localparam int FRAME_W = 1 + CHAN_W + RES_W;

    logic               cs_fall, cs_rise, sclk_rise, cap_evt;
    ctrl_head_t         cap_word;
    logic [CHAN_W-1:0]  chan;
    pwr_mode_e          mode;
    logic               ctrl_def;
    pwr_state_e         state;
    logic               frame_ok;
    logic [FRAME_W-1:0] frame_word;
    logic               valid_q;

    assign frame_ok   = ctrl_def && can_convert(state);
    assign frame_word = frame_ok ? {1'b0, chan, sample_in} : '0;

    adc_pc_serial #(.FRAME_W(FRAME_W)) u_serial (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .load_frame (frame_word),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_rise  (sclk_rise),
        .cap_evt    (cap_evt),
        .cap_word   (cap_word),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    adc_pc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cs_rise  (cs_rise),
        .cap_evt  (cap_evt),
        .cap_word (cap_word),
        .chan     (chan),
        .mode     (mode),
        .ctrl_def (ctrl_def)
    );

    adc_pc_pwr_fsm #(.PWRUP_SCLKS(PWRUP_SCLKS)) u_pwr (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .ctrl_def  (ctrl_def),
        .mode      (mode),
        .state     (state)
    );

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else if (cs_fall)
            valid_q <= frame_ok;
    end

    assign data_valid = valid_q;
    assign pwr_state  = state;

    assert_valid_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_fall |=> $stable(data_valid));
    assert_undef_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && !ctrl_def) |=> !data_valid);
    assert_off_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && state == PW_FULL_OFF) |=> !data_valid);

endmodule

// File: tb/sim_adc_power_ctrl.sv
module sim_adc_power_ctrl;

    localparam int RES_W = 12;
    localparam int PU    = 20;

    logic clk = 1'b0;
    logic rst, cs_n, sclk, din;
    logic [RES_W-1:0] sample_in;
    logic dout, dout_oe, data_valid;
    logic [1:0] pwr_state;

    always #2 clk = ~clk;

    adc_power_ctrl #(.RES_W(RES_W), .PWRUP_SCLKS(PU)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe),
        .data_valid(data_valid), .pwr_state(pwr_state)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit        m_def, m_oe, m_valid;
    int        m_chan, m_mode, m_por, m_state, m_tmr, m_pos;
    bit [15:0] m_word;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(dout_oe == m_oe, "R2 oe", int'(dout_oe), int'(m_oe));
            chk(data_valid == m_valid, "R10 valid", int'(data_valid), int'(m_valid));
            chk(int'(pwr_state) == m_state, cur_req, int'(pwr_state), m_state);
            if (m_oe)
                chk(dout == ((m_pos < 16) ? m_word[15 - m_pos] : 1'b0), "R6 dout",
                    int'(dout), int'((m_pos < 16) ? m_word[15 - m_pos] : 1'b0));
        end
    endtask

    task automatic frame(input bit [11:0] ctl, input bit [11:0] samp, input int nclk,
                         output bit [15:0] got, output bit got_v, output bit got_v_end,
                         output int got_s, output bit got_oe);
        got = '0;
        sample_in = samp;
        cs_n = 1'b0;
        m_oe = 1'b1;
        m_valid = m_def && (m_state == 0 || m_state == 1);
        m_word = m_valid ? {1'b0, m_chan[2:0], samp} : 16'h0;
        if (m_state == 1) m_state = 0;
        m_pos = 0;
        step(2);
        got_v = data_valid;
        got_s = int'(pwr_state);
        got_oe = dout_oe;
        for (int i = 0; i < nclk; i++) begin
            din = (i < 12) ? ctl[11 - i] : 1'b0;
            step(1);
            got[15 - i] = dout;
            sclk = 1'b1;
            if (i == 11 && m_por == 2 && ctl[11]) begin
                m_def = 1; m_chan = int'(ctl[10:8]); m_mode = int'(ctl[7:6]);
            end
            if (m_state == 3) begin
                m_tmr--;
                if (m_tmr == 0) m_state = 0;
            end
            step(2);
            sclk = 1'b0;
            m_pos++;
            step(2);
        end
        got_v_end = data_valid;
        cs_n = 1'b1;
        m_oe = 1'b0;
        if (m_def) begin
            if (m_mode == 2) m_state = 2;
            else if (m_state == 2) begin m_state = 3; m_tmr = PU; end
            else if (m_state != 3) m_state = (m_mode == 1) ? 1 : 0;
        end
        if (m_por < 2) m_por++;
        step(3);
    endtask

    task automatic full(input bit [11:0] ctl, input bit [11:0] samp,
                        input string req, input bit exp_v, input bit [15:0] exp_w);
        bit [15:0] g; bit v, ve, oe; int s;
        frame(ctl, samp, 16, g, v, ve, s, oe);
        chk(v == exp_v, req, int'(v), int'(exp_v));
        chk(g == exp_w, req, int'(g), int'(exp_w));
        chk(ve == v, "R10 held", int'(ve), int'(v));
        chk(oe == 1'b1, "R2 oe in frame", int'(oe), 1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        bit [15:0] g; bit v, ve, oe; int s;
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; sample_in = '0;
        m_def = 0; m_oe = 0; m_valid = 0; m_chan = 0; m_mode = 3;
        m_por = 0; m_state = 0; m_tmr = 0; m_pos = 0; m_word = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dout_oe == 1'b0, "R1 oe", int'(dout_oe), 0);
        chk(data_valid == 1'b0, "R1 valid", int'(data_valid), 0);
        chk(pwr_state == 2'd0, "R1 state", int'(pwr_state), 0);
        rst = 1'b0;
        step(2);

        // R5: two power-on dummy frames with din high, no load, invalid
        cur_req = "R5";
        full(12'hFFF, 12'h0AB, "R5 dummy1", 1'b0, 16'h0000);
        full(12'hFFF, 12'h0CD, "R5 dummy2", 1'b0, 16'h0000);
        // R5: third frame loads chan 3, mode on; still invalid
        full(12'hBC0, 12'h0EF, "R5 load frame", 1'b0, 16'h0000);
        // R3/R6: next frame valid, tagged with chan 3; write flag 0 with chan 6
        cur_req = "R3";
        full(12'h6C0, 12'hA5C, "R6 word", 1'b1, 16'h3A5C);
        // R4: channel unchanged after the write-0 frame
        full(12'h000, 12'h123, "R4 no write", 1'b1, 16'h3123);
        // R3: frame cut at 8 clocks cannot load chan 5
        frame(12'hDC0, 12'h000, 8, g, v, ve, s, oe);
        full(12'h000, 12'h0FF, "R3 short frame", 1'b1, 16'h30FF);

        // R7: auto sleep mode, chan 2
        cur_req = "R7";
        full(12'hA40, 12'h111, "R7 set auto", 1'b1, 16'h3111);
        chk(pwr_state == 2'd1, "R7 asleep", int'(pwr_state), 1);
        frame(12'h000, 12'h222, 16, g, v, ve, s, oe);
        chk(v == 1'b1 && g == 16'h2222, "R7 wake frame", int'(g), 16'h2222);
        chk(s == 0, "R7 awake in frame", s, 0);
        chk(pwr_state == 2'd1, "R7 asleep again", int'(pwr_state), 1);

        // R8: full shutdown
        cur_req = "R8";
        full(12'hA80, 12'h333, "R8 enter", 1'b1, 16'h2333);
        chk(pwr_state == 2'd2, "R8 off", int'(pwr_state), 2);
        full(12'h000, 12'h444, "R8 off frame", 1'b0, 16'h0000);
        chk(pwr_state == 2'd2, "R8 stays off", int'(pwr_state), 2);

        // R9: exit to mode on, chan 1, PU=20 spans into the second frame
        cur_req = "R9";
        full(12'h9C0, 12'h555, "R9 exit frame", 1'b0, 16'h0000);
        chk(pwr_state == 2'd3, "R9 waking", int'(pwr_state), 3);
        full(12'h000, 12'h666, "R9 dummy", 1'b0, 16'h0000);
        chk(pwr_state == 2'd3, "R9 still waking", int'(pwr_state), 3);
        full(12'h000, 12'h777, "R9 second dummy", 1'b0, 16'h0000);
        chk(pwr_state == 2'd0, "R9 on", int'(pwr_state), 0);
        full(12'h000, 12'h888, "R9 valid", 1'b1, 16'h1888);

        // R3: mode code 00 behaves as on
        cur_req = "R3";
        full(12'h900, 12'h999, "R3 mode00", 1'b1, 16'h1999);
        chk(pwr_state == 2'd0, "R3 mode00 state", int'(pwr_state), 0);
        full(12'h000, 12'hAAA, "R3 mode00 next", 1'b1, 16'h1AAA);
        chk(dout_oe == 1'b0, "R2 oe idle", int'(dout_oe), 0);

        finished = 1;
        finish_run();
    end

endmodule